// File: doc/BRIEF.md
# Load-Store Alias Protection Unit

This unit lets reordered code hoist a load above an earlier store and still detect when the reorder was unsafe. A load that is hoisted issues a protect request. The request writes the load's start address and access size into one slot of a small region table, and marks that slot valid. A later store that was moved below such loads issues a check. The check carries the store's address, its size and a bit mask that names the table slots to compare against. If the store's bytes overlap the bytes of any named, valid slot, the unit raises an alias exception. It also reports which slot matched, so that recovery software can repair the state. The unit does not act on the conflict itself.

A commit or a rollback pulses the clear input. This empties the whole table in one cycle and dismisses a pending exception. A small two-state controller governs the exception. In state ARMED no conflict is pending. A check that hits moves the controller to TRAPPED (transition ARMED->TRAPPED on a hitting check). TRAPPED holds the flag and the slot index steady until a clear (transition TRAPPED->ARMED on clear). In ARMED, a clear or a check that does not hit leaves the controller in ARMED.

Top module: `alias_guard`

## Requirements
- R1: After reset, exc_o is 0 and exc_idx_o is 0, and every slot is invalid: a check with all mask bits set raises nothing.
- R2: A protect request writes its address and size into the slot given by prot_idx_i and marks that slot valid. A second protect to the same slot replaces the old region entirely.
- R3: The size code gives the access length: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. A slot and a store overlap when their byte ranges [addr, addr+len) share at least one byte. Ranges that only touch end to end do not overlap.
- R4: Only slots whose bit is set in chk_mask_i (bit i selects slot i) take part in a check. A valid, overlapping slot outside the mask raises nothing.
- R5: The exception is registered. exc_o goes to 1 at the first rising edge after the cycle in which a hitting check is presented. At that same edge, exc_idx_o takes the lowest slot number that matched. While exc_o is 0, exc_idx_o is 0.
- R6: Once raised, exc_o and exc_idx_o hold their values until a clear, whatever later checks present.
- R7: A clear empties every slot and drops exc_o and exc_idx_o to 0 at the next edge. A check presented in the same cycle as a clear is ignored.
- R8: A protect presented in the same cycle as a clear is recorded, and its slot is valid after that edge.
- R9: A check presented in the same cycle as a protect compares against the table as it stood before that protect.
- R10: Range ends are computed with one extra bit, so a region near the top of the address space does not wrap around to match low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_vld_i | input | 1 | Protect request valid |
| prot_idx_i | input | IDX_W (3) | Slot to write |
| prot_addr_i | input | ADDR_W (32) | Start address of the loaded data |
| prot_size_i | input | 2 | Size code of the load |
| chk_vld_i | input | 1 | Store check valid |
| chk_addr_i | input | ADDR_W (32) | Start address of the store |
| chk_size_i | input | 2 | Size code of the store |
| chk_mask_i | input | ENTRIES (8) | Slots to compare, bit i selects slot i |
| clear_i | input | 1 | Commit or rollback: empty the table and dismiss the exception |
| exc_o | output | 1 | Alias exception pending |
| exc_idx_o | output | IDX_W (3) | Lowest matching slot of the pending exception |

## Verification
Every result of this unit falls due exactly one rising edge after its stimulus. This covers a table write, a raised exception with its slot index, and the flag dropping after a clear. Nothing becomes visible combinationally, and nothing takes longer than one edge. The bench drives each stimulus at a falling edge. Its behavioural model advances at the following rising edge, and the bench compares exc_o and exc_idx_o with the model at the next falling edge, once per cycle. Same-cycle collisions are driven deliberately so that the ordering rules are checked at that single edge: clear with check, clear with protect, and protect with check on the same slot.

// File: rtl/alias_guard_pkg.sv
package alias_guard_pkg;

    localparam int SIZE_W = 2;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_TRAPPED = 1'b1
    } guard_state_e;

    // Byte length for a size code: 1, 2, 4 or 8.
    function automatic logic [3:0] span_bytes(input logic [SIZE_W-1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/alias_region_table.sv
module alias_region_table
    import alias_guard_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear_i,
    input  logic                             wr_en_i,
    input  logic [IDX_W-1:0]                 wr_idx_i,
    input  logic [ADDR_W-1:0]                wr_addr_i,
    input  logic [SIZE_W-1:0]                wr_size_i,
    output logic [ENTRIES-1:0]               valid_o,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   base_o,
    output logic [ENTRIES-1:0][SIZE_W-1:0]   size_o
);

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] base_q;
    logic [ENTRIES-1:0][SIZE_W-1:0] size_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic sel;
        assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                base_q[g]  <= '0;
                size_q[g]  <= '0;
            end else begin
                if (sel) begin
                    valid_q[g] <= 1'b1;
                    base_q[g]  <= wr_addr_i;
                    size_q[g]  <= wr_size_i;
                end else if (clear_i) begin
                    valid_q[g] <= 1'b0;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign base_o  = base_q;
    assign size_o  = size_q;

    assert_protect_marks_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> valid_q[$past(wr_idx_i)]);

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !wr_en_i) |=> (valid_q == '0));

endmodule

// File: rtl/alias_range_cmp.sv
module alias_range_cmp
    import alias_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] a_base_i,
    input  logic [SIZE_W-1:0] a_size_i,
    input  logic [ADDR_W-1:0] b_base_i,
    input  logic [SIZE_W-1:0] b_size_i,
    output logic              overlap_o
);

    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo = {1'b0, a_base_i};
        b_lo = {1'b0, b_base_i};
        a_hi = a_lo + EXT_W'(span_bytes(a_size_i));
        b_hi = b_lo + EXT_W'(span_bytes(b_size_i));
        overlap_o = (a_lo < b_hi) && (b_lo < a_hi);
    end

endmodule

// File: rtl/alias_lowest_pick.sv
module alias_lowest_pick #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] hit_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |hit_i;
    end

endmodule

// File: rtl/alias_guard.sv
module alias_guard
    import alias_guard_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prot_vld_i,
    input  logic [IDX_W-1:0]   prot_idx_i,
    input  logic [ADDR_W-1:0]  prot_addr_i,
    input  logic [1:0]         prot_size_i,
    input  logic               chk_vld_i,
    input  logic [ADDR_W-1:0]  chk_addr_i,
    input  logic [1:0]         chk_size_i,
    input  logic [ENTRIES-1:0] chk_mask_i,
    input  logic               clear_i,
    output logic               exc_o,
    output logic [IDX_W-1:0]   exc_idx_o
);

    logic [ENTRIES-1:0]             slot_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] slot_base;
    logic [ENTRIES-1:0][SIZE_W-1:0] slot_size;
    logic [ENTRIES-1:0]             slot_overlap;
    logic [ENTRIES-1:0]             slot_hit;
    logic                           any_hit;
    logic [IDX_W-1:0]               first_hit;

    guard_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             raise;

    alias_region_table #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .wr_en_i   (prot_vld_i),
        .wr_idx_i  (prot_idx_i),
        .wr_addr_i (prot_addr_i),
        .wr_size_i (prot_size_i),
        .valid_o   (slot_valid),
        .base_o    (slot_base),
        .size_o    (slot_size)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        alias_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .a_base_i  (slot_base[g]),
            .a_size_i  (slot_size[g]),
            .b_base_i  (chk_addr_i),
            .b_size_i  (chk_size_i),
            .overlap_o (slot_overlap[g])
        );
    end

    assign slot_hit = slot_valid & chk_mask_i & slot_overlap;

    alias_lowest_pick #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_pick (
        .hit_i (slot_hit),
        .any_o (any_hit),
        .idx_o (first_hit)
    );

    assign raise = (state_q == ST_ARMED) && chk_vld_i && any_hit && !clear_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:   if (raise)   state_d = ST_TRAPPED;
            ST_TRAPPED: if (clear_i) state_d = ST_ARMED;
            default:                 state_d = ST_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       idx_q <= '0;
        else if (clear_i) idx_q <= '0;
        else if (raise)   idx_q <= first_hit;
    end

    assign exc_o     = (state_q == ST_TRAPPED);
    assign exc_idx_o = idx_q;

    assert_clear_drops_exc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!exc_o && exc_idx_o == '0));

    assert_held_until_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_o && !clear_i) |=> (exc_o && $stable(exc_idx_o)));

    assert_raise_from_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_o) |-> ($past(chk_vld_i) && !$past(clear_i)));

    assert_idle_index_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_o |-> (exc_idx_o == '0));

endmodule

// File: tb/alias_guard_test.sv
module alias_guard_test;

    localparam int N  = 8;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prot_vld_i = 1'b0;
    logic [2:0]    prot_idx_i = '0;
    logic [AW-1:0] prot_addr_i = '0;
    logic [1:0]    prot_size_i = '0;
    logic          chk_vld_i = 1'b0;
    logic [AW-1:0] chk_addr_i = '0;
    logic [1:0]    chk_size_i = '0;
    logic [N-1:0]  chk_mask_i = '0;
    logic          clear_i = 1'b0;
    logic          exc_o;
    logic [2:0]    exc_idx_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string tag = "R1";

    // behavioural model
    bit     m_v [N];
    longint m_a [N];
    int     m_s [N];
    bit     m_exc = 0;
    int     m_idx = 0;

    always #5 clk = ~clk;

    alias_guard uut (
        .clk, .rst_n, .prot_vld_i, .prot_idx_i, .prot_addr_i, .prot_size_i,
        .chk_vld_i, .chk_addr_i, .chk_size_i, .chk_mask_i, .clear_i,
        .exc_o, .exc_idx_o
    );

    function automatic bit ovl(longint a, int sa, longint b, int sb);
        longint ae = a + (longint'(1) << sa);
        longint be = b + (longint'(1) << sb);
        return (a < be) && (b < ae);
    endfunction

    task automatic model_edge();
        bit hit = 0;
        if (clear_i) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_exc = 0;
            m_idx = 0;
        end else if (chk_vld_i && !m_exc) begin
            for (int i = 0; i < N; i++) begin
                if (!hit && chk_mask_i[i] && m_v[i] &&
                    ovl(m_a[i], m_s[i], longint'(chk_addr_i), int'(chk_size_i))) begin
                    hit = 1;
                    m_exc = 1;
                    m_idx = i;
                end
            end
        end
        if (prot_vld_i) begin
            m_v[prot_idx_i] = 1;
            m_a[prot_idx_i] = longint'(prot_addr_i);
            m_s[prot_idx_i] = int'(prot_size_i);
        end
    endtask

    task automatic compare();
        total++;
        if (exc_o !== m_exc || int'(exc_idx_o) != m_idx) begin
            bad++;
            $display("FAIL %s: exc=%0b idx=%0d expected exc=%0b idx=%0d",
                     tag, exc_o, exc_idx_o, m_exc, m_idx);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        prot_vld_i = 0;
        chk_vld_i  = 0;
        clear_i    = 0;
    endtask

    task automatic set_prot(int idx, longint addr, int sz);
        prot_vld_i  = 1;
        prot_idx_i  = 3'(idx);
        prot_addr_i = AW'(addr);
        prot_size_i = 2'(sz);
    endtask

    task automatic set_chk(longint addr, int sz, int mask);
        chk_vld_i  = 1;
        chk_addr_i = AW'(addr);
        chk_size_i = 2'(sz);
        chk_mask_i = N'(mask);
    endtask

    task automatic do_clear();
        clear_i = 1;
        cyc();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_a[i] = 0; m_s[i] = 0; end
        repeat (3) @(negedge clk);
        tag = "R1 reset";
        compare();
        rst_n = 1;
        @(negedge clk);
        tag = "R1 empty table";
        set_chk(0, 3, 'hFF); cyc();
        set_chk('h100, 3, 'hFF); cyc();

        // R3 / R5 basic hit, due one edge later
        tag = "R3 R5 basic hit";
        set_prot(0, 'h100, 2); cyc();
        set_chk('h103, 0, 'hFF); cyc();
        cyc();
        tag = "R7 clear";
        do_clear();
        set_chk('h100, 2, 'hFF); cyc();

        // R3 adjacency
        tag = "R3 adjacent";
        set_prot(1, 'h200, 3); cyc();
        set_chk('h1F8, 3, 'hFF); cyc();
        set_chk('h208, 3, 'hFF); cyc();
        tag = "R3 one byte shared";
        set_chk('h1FF, 1, 'hFF); cyc();
        do_clear();

        // R4 mask and R5 lowest index
        tag = "R4 mask excludes";
        set_prot(2, 'h300, 2); cyc();
        set_prot(5, 'h302, 1); cyc();
        set_chk('h300, 3, 'h00); cyc();
        set_chk('h300, 3, 'hDB); cyc();
        tag = "R4 mask picks 5";
        do_clear();
        set_prot(2, 'h300, 2); cyc();
        set_prot(5, 'h302, 1); cyc();
        set_chk('h300, 3, 'h20); cyc();
        do_clear();
        tag = "R5 lowest";
        set_prot(2, 'h300, 2); cyc();
        set_prot(5, 'h302, 1); cyc();
        set_chk('h300, 3, 'hFF); cyc();

        // R6 sticky
        tag = "R6 hold";
        set_prot(0, 'h302, 0); cyc();
        set_chk('h302, 0, 'hFF); cyc();
        cyc();
        // R7 check with clear ignored
        tag = "R7 check with clear";
        clear_i = 1; set_chk('h300, 3, 'hFF); cyc();
        cyc();

        // R8 protect with clear survives
        tag = "R8 protect with clear";
        set_prot(4, 'h500, 3); cyc();
        clear_i = 1; set_prot(3, 'h700, 2); cyc();
        set_chk('h500, 3, 'hFF); cyc();
        set_chk('h702, 0, 'hFF); cyc();
        do_clear();

        // R9 same-cycle protect and check
        tag = "R9 same cycle";
        set_prot(6, 'h600, 2); set_chk('h600, 0, 'h40); cyc();
        set_chk('h600, 0, 'h40); cyc();
        do_clear();

        // R2 rewrite
        tag = "R2 rewrite";
        set_prot(3, 'h400, 3); cyc();
        set_prot(3, 'h800, 3); cyc();
        set_chk('h400, 3, 'hFF); cyc();
        set_chk('h804, 2, 'hFF); cyc();
        do_clear();

        // R10 no wrap
        tag = "R10 top of space";
        set_prot(7, 'hFFFF_FFF8, 3); cyc();
        set_chk(0, 3, 'hFF); cyc();
        set_chk('hFFFF_FFFC, 2, 'hFF); cyc();
        do_clear();

        // R3 random traffic
        tag = "R3 random";
        for (int k = 0; k < 600; k++) begin
            int r = int'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1)
                set_prot(int'($urandom_range(0, 7)), 'h1000 + longint'($urandom_range(0, 63)),
                         int'($urandom_range(0, 3)));
            if ($urandom_range(0, 2) != 0)
                set_chk('h1000 + longint'($urandom_range(0, 63)), int'($urandom_range(0, 3)),
                        int'($urandom_range(0, 255)));
            if (r == 0) clear_i = 1;
            cyc();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule